// File: doc/BRIEF.md
# Current-Mode PWM Sequencer with Soft-Start

This block is the digital timing core of a single-switch power converter controller. It makes a fixed-frequency gate pulse from a period counter. Each pulse starts at a period boundary. It ends on the first of three events: a comparator trip, the hard duty cap of four fifths of the period, or the soft-start duty ceiling. Two asynchronous comparator inputs are used. One is the peak-current (PWM) comparator and the other is the over-current limit comparator. Both pass through a synchronizer, and both are masked for a short leading-edge blanking window after each turn-on, so switching noise cannot end a pulse early.

A digital soft-start ramp controls start-up. The ramp is a level counter that advances one step per programmable number of clocks, in units of 10 mV of an equivalent soft-start voltage. The gate stays off until the level passes 0.45 V. Above that point the duty ceiling grows in proportion to the level and reaches the full cap at 1.6 V. The ramp is cleared and held at zero while either supply is in power-on reset or while the block is disabled. A supply over-voltage flag blocks the gate without clearing the ramp.

Top module: `pwm_seq_top`

## Requirements
- R1: `gate` is 0 during reset and goes to 0 on the first rising edge at which `en` is sampled low.
- R2: The effective period P is `period_cyc` clamped to the range 200..1000 clocks (100 kHz to 500 kHz at 100 MHz). A new value takes effect at a period boundary. Once running, `gate` rises exactly once every P clocks.
- R3: Once soft-start has completed and no comparator trips, each pulse lasts floor(4*P/5) clocks, and no pulse is ever longer.
- R4: When either comparator input rises outside the blanking window, `gate` falls on the third rising clock edge after that input rise: two synchronizer stages, then the output register.
- R5: During the first 10 clocks of each pulse, the synchronized comparator values are ignored. An assertion that ends before this window closes does not shorten the pulse. An assertion still present when the window closes ends the pulse after exactly 11 clocks.
- R6: The soft-start level advances by one every `ss_rate`+1 clocks and stops at 160. The gate stays low until the level exceeds 45. After that the pulse ceiling is floor((level-45)*floor(4P/5)/115), so pulse widths never decrease while the ramp rises.
- R7: While `por_hi` or `por_lo` is high, the ramp is held at zero and `gate` is 0 from the next rising edge. After release, a full soft-start is needed before the first pulse.
- R8: While `ovlo` is high, `gate` is 0 from the next rising edge. The ramp level is kept, so pulses resume at full width when `ovlo` clears.
- R9: Driving `en` low clears the soft-start ramp. After re-enable, no pulse appears until the ramp again exceeds 45.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, 100 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| por_hi | input | 1 | High-side supply in power-on reset |
| por_lo | input | 1 | Low-side supply in power-on reset |
| ovlo | input | 1 | High-side supply over-voltage flag |
| cmp_pwm | input | 1 | Asynchronous peak-current comparator output |
| cmp_ilim | input | 1 | Asynchronous current-limit comparator output |
| period_cyc | input | 10 | Requested switching period in clocks |
| ss_rate | input | 8 | Soft-start step interval minus one, in clocks |
| gate | output | 1 | Switch gate drive |

## Verification
The bench targets the edges of the blanking window. A trip that starts inside the window and holds past it must give an 11-clock pulse. If the mask were off by one, that pulse would be 10 or 12 clocks, and a short glitch inside the window would cut the pulse short instead of being ignored. Period requests below and above the legal range check the clamp; a design without it would run at 100 or 1023 clocks. The bench also checks the first pulse delay after power-on reset and after re-enable. A ramp that was not cleared would switch at once. Over-voltage recovery must resume at full width, and a design that cleared the ramp on over-voltage would come back with narrow pulses.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
    localparam int PER_W  = 10;
    localparam int SS_W   = 8;
    localparam int RATE_W = 8;
    localparam int NCMP   = 2;

    typedef struct packed {
        logic [PER_W-1:0] ph;
        logic [PER_W-1:0] per;
    } tbase_t;

    typedef struct packed {
        logic [SS_W-1:0]   lvl;
        logic [RATE_W-1:0] pre;
    } ramp_t;

    typedef struct packed {
        logic             gate;
        logic [PER_W-1:0] on;
    } pulse_t;
endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef logic [STAGES-1:0][W-1:0] chain_t;
    chain_t ch_d, ch_q;

    always_comb begin
        ch_d    = ch_q;
        ch_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            ch_d[i] = ch_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign dout = ch_q[STAGES-1];
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_seq_pkg::*;
#(
    parameter int MIN_PER = 200,
    parameter int MAX_PER = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_in,
    output logic             wrap,
    output logic [PER_W-1:0] dmax
);
    localparam int PROD_W = PER_W + 3;
    localparam int CMP_W  = PER_W + 1;

    tbase_t           s_d, s_q;
    logic [PER_W-1:0] per_clamped;
    logic [PROD_W-1:0] prod;

    always_comb begin
        if (period_in < PER_W'(MIN_PER))      per_clamped = PER_W'(MIN_PER);
        else if (period_in > PER_W'(MAX_PER)) per_clamped = PER_W'(MAX_PER);
        else                                  per_clamped = period_in;

        wrap = (CMP_W'(s_q.ph) + CMP_W'(1)) >= CMP_W'(s_q.per);

        s_d = s_q;
        if (wrap) begin
            s_d.ph  = '0;
            s_d.per = per_clamped;
        end else begin
            s_d.ph  = s_q.ph + PER_W'(1);
        end

        prod = PROD_W'(s_q.per) << 2;
        dmax = PER_W'(prod / PROD_W'(5));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph  <= '0;
            s_q.per <= PER_W'(MIN_PER);
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/pwm_softstart.sv
module pwm_softstart
    import pwm_seq_pkg::*;
#(
    parameter int SS_EN   = 45,
    parameter int SS_FULL = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [RATE_W-1:0] rate,
    input  logic [PER_W-1:0]  dmax,
    output logic [SS_W-1:0]   lvl,
    output logic [PER_W-1:0]  ceil_cyc,
    output logic              ready
);
    localparam int SPAN  = SS_FULL - SS_EN;
    localparam int MUL_W = SS_W + PER_W;

    ramp_t            r_d, r_q;
    logic [SS_W-1:0]  over;
    logic [MUL_W-1:0] mul;

    always_comb begin
        r_d = r_q;
        if (hold) begin
            r_d = '0;
        end else if (r_q.lvl < SS_W'(SS_FULL)) begin
            if (r_q.pre >= rate) begin
                r_d.pre = '0;
                r_d.lvl = r_q.lvl + SS_W'(1);
            end else begin
                r_d.pre = r_q.pre + RATE_W'(1);
            end
        end

        over     = (r_q.lvl > SS_W'(SS_EN)) ? (r_q.lvl - SS_W'(SS_EN)) : '0;
        mul      = MUL_W'(over) * MUL_W'(dmax);
        ceil_cyc = PER_W'(mul / MUL_W'(SPAN));
        ready    = (r_q.lvl >= SS_W'(SS_EN));
        lvl      = r_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pwm_seq_top.sv
module pwm_seq_top
    import pwm_seq_pkg::*;
#(
    parameter int MIN_PER     = 200,
    parameter int MAX_PER     = 1000,
    parameter int BLANK_CYC   = 10,
    parameter int SYNC_STAGES = 2,
    parameter int SS_EN       = 45,
    parameter int SS_FULL     = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              por_hi,
    input  logic              por_lo,
    input  logic              ovlo,
    input  logic              cmp_pwm,
    input  logic              cmp_ilim,
    input  logic [PER_W-1:0]  period_cyc,
    input  logic [RATE_W-1:0] ss_rate,
    output logic              gate
);
    localparam int CMP_W = PER_W + 1;

    logic [NCMP-1:0]  cmp_s;
    logic             wrap;
    logic [PER_W-1:0] dmax_w;
    logic [SS_W-1:0]  ss_lvl_w;
    logic [PER_W-1:0] ceil_w;
    logic             ss_ready;
    logic             ss_hold;
    logic             run;
    logic             trip;
    logic             at_limit;

    pulse_t p_d, p_q;

    pwm_sync #(.W(NCMP), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cmp_ilim, cmp_pwm}),
        .dout (cmp_s)
    );

    pwm_timebase #(.MIN_PER(MIN_PER), .MAX_PER(MAX_PER)) u_tbase (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_in(period_cyc),
        .wrap     (wrap),
        .dmax     (dmax_w)
    );

    assign ss_hold = !en || por_hi || por_lo;

    pwm_softstart #(.SS_EN(SS_EN), .SS_FULL(SS_FULL)) u_ss (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (ss_hold),
        .rate    (ss_rate),
        .dmax    (dmax_w),
        .lvl     (ss_lvl_w),
        .ceil_cyc(ceil_w),
        .ready   (ss_ready)
    );

    always_comb begin
        run      = en && !por_hi && !por_lo && !ovlo && ss_ready;
        trip     = (|cmp_s) && (p_q.on >= PER_W'(BLANK_CYC));
        at_limit = (CMP_W'(p_q.on) + CMP_W'(1)) >= CMP_W'(ceil_w);

        p_d = p_q;
        if (!run) begin
            p_d.gate = 1'b0;
            p_d.on   = '0;
        end else if (wrap) begin
            p_d.gate = (ceil_w != '0);
            p_d.on   = '0;
        end else if (p_q.gate) begin
            p_d.on = p_q.on + PER_W'(1);
            if (at_limit || trip) p_d.gate = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign gate = p_q.gate;
endmodule

// File: rtl/pwm_seq_chk.sv
module pwm_seq_chk
    import pwm_seq_pkg::*;
#(
    parameter int MIN_PER = 200
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             por_hi,
    input logic             por_lo,
    input logic             ovlo,
    input logic             gate,
    input logic [PER_W-1:0] dmax,
    input logic [SS_W-1:0]  lvl
);
    logic [15:0] hi_cnt;
    logic [15:0] since;
    logic        gate_prev;
    logic        seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt    <= '0;
            since     <= '0;
            gate_prev <= 1'b0;
            seen      <= 1'b0;
        end else begin
            hi_cnt    <= gate ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1) : 16'd0;
            gate_prev <= gate;
            if (gate && !gate_prev) begin
                since <= 16'd1;
                seen  <= 1'b1;
            end else if (since != 16'hFFFF) begin
                since <= since + 16'd1;
            end
        end
    end

    // R1
    gate_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !gate);

    // R8
    gate_off_on_ovlo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovlo |=> !gate);

    // R7
    gate_off_on_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (por_hi || por_lo) |=> (!gate && lvl == '0));

    // R9
    ramp_cleared_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (lvl == '0));

    // R3
    duty_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (hi_cnt < 16'(dmax)));

    // R2
    min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !gate_prev && seen) |-> (since >= 16'(MIN_PER)));
endmodule

bind pwm_seq_top pwm_seq_chk #(.MIN_PER(MIN_PER)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .por_hi(por_hi),
    .por_lo(por_lo),
    .ovlo  (ovlo),
    .gate  (gate),
    .dmax  (dmax_w),
    .lvl   (ss_lvl_w)
);

// File: tb/tb_pwm_seq_top.sv
`timescale 1ns/1ps
module tb_pwm_seq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       por_hi = 1'b0;
    logic       por_lo = 1'b0;
    logic       ovlo = 1'b0;
    logic       cmp_pwm = 1'b0;
    logic       cmp_ilim = 1'b0;
    logic [9:0] period_cyc = 10'd200;
    logic [7:0] ss_rate = 8'd0;
    logic       gate;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_seq_top dut (
        .clk(clk), .rst_n(rst_n), .en(en), .por_hi(por_hi), .por_lo(por_lo),
        .ovlo(ovlo), .cmp_pwm(cmp_pwm), .cmp_ilim(cmp_ilim),
        .period_cyc(period_cyc), .ss_rate(ss_rate), .gate(gate)
    );

    // columns: period request, comparator (0 none, 1 pwm, 2 ilim), start offset, hold, width, period
    localparam int NVEC = 11;
    localparam int VEC [0:NVEC-1][0:5] = '{
        '{ 200, 0,   0,  0, 160,  200},
        '{1000, 0,   0,  0, 800, 1000},
        '{ 333, 0,   0,  0, 266,  333},
        '{ 200, 2,  20,  5,  23,  200},
        '{ 200, 1,  50,  5,  53,  200},
        '{ 200, 2,   2, 30,  11,  200},
        '{ 200, 1,   0,  4, 160,  200},
        '{ 100, 0,   0,  0, 160,  200},
        '{1023, 0,   0,  0, 800, 1000},
        '{ 250, 2,   7,  3,  11,  250},
        '{ 500, 1, 300, 10, 303,  500}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // returns at the negedge where gate is first seen high; n = negedges waited
    task automatic wait_rise(output int n);
        logic p;
        p = gate;
        n = 0;
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            n++;
            if (gate && !p) return;
            p = gate;
        end
        n = -1;
    endtask

    task automatic drive_cmp(input int sel, input logic v);
        if (sel == 1) cmp_pwm = v;
        else if (sel == 2) cmp_ilim = v;
    endtask

    // called at the negedge of a rise; measures pulse width and rise-to-rise time
    task automatic measure(input int sel, input int j, input int hold,
                           output int width, output int per);
        logic p;
        bit   fell;
        p = 1'b1;
        fell = 1'b0;
        width = 0;
        per = -1;
        for (int c = 0; c < 3000; c++) begin
            if (c > 0) begin
                @(negedge clk);
                if (gate && !p) begin
                    per = c;
                    return;
                end
            end
            if (gate && !fell) width++;
            else fell = 1'b1;
            if (sel != 0 && c == j) drive_cmp(sel, 1'b1);
            if (sel != 0 && c == j + hold) drive_cmp(sel, 1'b0);
            p = gate;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, w, p, hi, prev_w;
        bit mono;

        // R1: reset state
        repeat (5) @(negedge clk);
        check(gate == 1'b0, "R1 gate in reset", gate, 0);
        rst_n = 1'b1;

        // R1: disabled, gate stays low
        hi = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (gate) hi++;
        end
        check(hi == 0, "R1 gate while disabled", hi, 0);

        en = 1'b1;
        ss_rate = 8'd0;
        repeat (600) @(negedge clk);

        // vector table: R2 period, R3 cap, R4 trip, R5 blanking
        for (int v = 0; v < NVEC; v++) begin
            period_cyc = 10'(VEC[v][0]);
            wait_rise(n);
            wait_rise(n);
            wait_rise(n);
            measure(VEC[v][1], VEC[v][2], VEC[v][3], w, p);
            if (VEC[v][1] == 0)
                check(w == VEC[v][4], "R3 pulse width", w, VEC[v][4]);
            else if (VEC[v][2] + 2 < 10)
                check(w == VEC[v][4], "R5 blanked width", w, VEC[v][4]);
            else
                check(w == VEC[v][4], "R4 trip width", w, VEC[v][4]);
            check(p == VEC[v][5], "R2 period", p, VEC[v][5]);
        end
        cmp_pwm = 1'b0;
        cmp_ilim = 1'b0;
        period_cyc = 10'd200;
        wait_rise(n);
        wait_rise(n);

        // R8: over-voltage mid-pulse
        wait_rise(n);
        repeat (20) @(negedge clk);
        ovlo = 1'b1;
        @(negedge clk);
        check(gate == 1'b0, "R8 gate off after ovlo", gate, 0);
        hi = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (gate) hi++;
        end
        check(hi == 0, "R8 gate held off", hi, 0);
        ovlo = 1'b0;
        wait_rise(n);
        measure(0, 0, 0, w, p);
        check(w == 160, "R8 full width after ovlo", w, 160);

        // R7: power-on reset holds ramp; R6 soft-start on release
        por_lo = 1'b1;
        @(negedge clk);
        check(gate == 1'b0, "R7 gate off on por", gate, 0);
        hi = 0;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (gate) hi++;
        end
        check(hi == 0, "R7 gate held off in por", hi, 0);
        ss_rate = 8'd20;
        por_lo = 1'b0;
        wait_rise(n);
        check(n >= 966 && n <= 1171, "R7 first pulse delay after por", n, 966);
        measure(0, 0, 0, w, p);
        check(w < 160 && w > 0, "R6 first soft pulse narrow", w, 1);
        prev_w = w;
        mono = 1'b1;
        for (int k = 0; k < 24; k++) begin
            measure(0, 0, 0, w, p);
            if (w < prev_w || w > 160) mono = 1'b0;
            prev_w = w;
        end
        check(mono, "R6 widths nondecreasing", prev_w, 160);
        check(prev_w == 160, "R6 ramp reaches cap", prev_w, 160);

        // R9: disable clears ramp
        wait_rise(n);
        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(gate == 1'b0, "R1 gate off on disable", gate, 0);
        repeat (50) @(negedge clk);
        en = 1'b1;
        wait_rise(n);
        check(n >= 966, "R9 soft-start after re-enable", n, 966);

        // R7: high-side por mid-pulse
        ss_rate = 8'd0;
        repeat (4000) @(negedge clk);
        wait_rise(n);
        repeat (3) @(negedge clk);
        por_hi = 1'b1;
        @(negedge clk);
        check(gate == 1'b0, "R7 gate off on high-side por", gate, 0);
        por_hi = 1'b0;
        repeat (10) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule